// File: doc/BRIEF.md
# Branch Condition and Counter Unit

This unit decides whether a conditional branch is taken and which address comes next. A branch can be made to depend on the loop-count register, on one bit of the condition word, or on both. The count test checks for zero or non-zero. The bit test checks for set or clear. The count register lives inside the unit. A branch can decrement it, and it can be written from a dedicated load port.

A branch is issued by holding `start_i` high for one clock cycle. In that cycle the caller also supplies:
- the mode code;
- the decrement enable;
- the target select;
- the condition word and a one-hot mask naming the bit to test;
- the immediate target, the link value and the fall-through address.

One clock later the unit presents the registered taken flag and next address, together with a one-cycle valid pulse. The count register is updated at that same edge. A target taken from a register always has its two low bits cleared, so the address it produces is word aligned.

Top module: `brc_unit`

## Requirements
- R1: Mode 0 is taken exactly when `cr_i & mask_i` is non-zero. Mode 1 is taken exactly when `cr_i & mask_i` is zero. Neither mode looks at the count.
- R2: Modes 2, 3 and 4 require the tested count to be non-zero. Mode 2 also requires the selected bit to be set, and mode 3 requires it to be clear. Mode 4 tests the count only.
- R3: Modes 5, 6 and 7 require the tested count to be zero. Mode 5 also requires the selected bit to be set, and mode 6 requires it to be clear. Mode 7 tests the count only.
- R4: A start with `dec_en_i` high lowers the count register by exactly one, wrapping modulo 2^W (0 becomes all ones). The count test then uses the decremented value. With `dec_en_i` low, the count test uses the current value and the count is unchanged.
- R5: For a taken branch, `tgt_sel_i` chooses the next address:
  - 0 or 3: the immediate target, unchanged.
  - 1: the count register value from before this branch's decrement, with bits [1:0] cleared.
  - 2: `lr_i` with bits [1:0] cleared.
- R6: A branch that is not taken produces `fall_addr_i` as the next address.
- R7: `taken_o` and `next_addr_o` are registered and change only at the clock edge that samples `start_i`. `valid_o` is high for exactly the one cycle after each start. Both results hold their values until the next start.
- R8: When `ctr_load_i` is high and `start_i` is low, `ctr_wdata_i` is written into the count register at that edge. When `start_i` is high in the same cycle, the load is ignored.
- R9: Synchronous active-high reset clears the count register, `taken_o`, `next_addr_o` and `valid_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Evaluate a branch this cycle |
| mode_i | input | 3 | Branch test mode code (R1 to R3) |
| dec_en_i | input | 1 | Decrement the count before testing it |
| tgt_sel_i | input | 2 | Target source select |
| cr_i | input | W | Condition word |
| mask_i | input | W | One-hot bit-select mask |
| imm_tgt_i | input | W | Immediate branch target |
| lr_i | input | W | Link register value |
| fall_addr_i | input | W | Fall-through address |
| ctr_load_i | input | 1 | Write the count register |
| ctr_wdata_i | input | W | Count register write value |
| taken_o | output | 1 | Branch taken flag |
| next_addr_o | output | W | Next instruction address |
| valid_o | output | 1 | Result valid pulse |
| ctr_o | output | W | Current count register value |

## Verification
`taken_o`, `next_addr_o` and `valid_o` are due one clock edge after the cycle in which `start_i` is high. `ctr_o` reflects a decrement or a load at that same edge. The bench drives inputs on the falling edge, and a behavioural model updates on the rising edge. Every output is compared on the next falling edge, so each result is checked exactly one edge after its stimulus. Because the comparison runs on every cycle, the idle cycles between starts also confirm that the results hold and that `valid_o` drops.

// File: rtl/brc_pkg.sv
package brc_pkg;

    typedef enum logic [2:0] {
        MODE_BIT_SET = 3'd0,
        MODE_BIT_CLR = 3'd1,
        MODE_NZ_SET  = 3'd2,
        MODE_NZ_CLR  = 3'd3,
        MODE_NZ      = 3'd4,
        MODE_Z_SET   = 3'd5,
        MODE_Z_CLR   = 3'd6,
        MODE_Z       = 3'd7
    } brc_mode_e;

    typedef enum logic [1:0] {
        TGT_IMM  = 2'd0,
        TGT_CTR  = 2'd1,
        TGT_LR   = 2'd2,
        TGT_RSVD = 2'd3
    } brc_tgt_e;

    // Which tests a mode applies
    typedef struct packed {
        logic need_nz;
        logic need_z;
        logic use_bit;
        logic want_set;
    } brc_test_t;

    function automatic brc_test_t decode_mode(brc_mode_e m);
        brc_test_t t;
        t = '0;
        case (m)
            MODE_BIT_SET: begin t.use_bit = 1'b1; t.want_set = 1'b1; end
            MODE_BIT_CLR: begin t.use_bit = 1'b1; end
            MODE_NZ_SET:  begin t.need_nz = 1'b1; t.use_bit = 1'b1; t.want_set = 1'b1; end
            MODE_NZ_CLR:  begin t.need_nz = 1'b1; t.use_bit = 1'b1; end
            MODE_NZ:      begin t.need_nz = 1'b1; end
            MODE_Z_SET:   begin t.need_z = 1'b1; t.use_bit = 1'b1; t.want_set = 1'b1; end
            MODE_Z_CLR:   begin t.need_z = 1'b1; t.use_bit = 1'b1; end
            default:      begin t.need_z = 1'b1; end
        endcase
        return t;
    endfunction

endpackage

// File: rtl/brc_count_reg.sv
module brc_count_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic         dec_en_i,
    input  logic         load_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] ctr_q_o,
    output logic [W-1:0] ctr_eval_o
);
    logic [W-1:0] ctr_q;
    logic [W-1:0] ctr_dec;

    assign ctr_dec    = ctr_q - W'(1);
    assign ctr_eval_o = dec_en_i ? ctr_dec : ctr_q;
    assign ctr_q_o    = ctr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctr_q <= '0;
        end else if (start_i) begin
            ctr_q <= ctr_eval_o;
        end else if (load_i) begin
            ctr_q <= wdata_i;
        end
    end

    AST_CTR_DEC_ONE: assert property (@(posedge clk) disable iff (rst)
        start_i && dec_en_i |=> ctr_q == $past(ctr_q) - W'(1)); // R4

    AST_CTR_LOAD: assert property (@(posedge clk) disable iff (rst)
        load_i && !start_i |=> ctr_q == $past(wdata_i)); // R8

    AST_CTR_LOAD_IGNORED: assert property (@(posedge clk) disable iff (rst)
        start_i && !dec_en_i |=> $stable(ctr_q)); // R8

endmodule

// File: rtl/brc_cond_eval.sv
module brc_cond_eval
    import brc_pkg::*;
#(
    parameter int W = 32
) (
    input  brc_mode_e    mode_i,
    input  logic [W-1:0] cr_i,
    input  logic [W-1:0] mask_i,
    input  logic [W-1:0] cnt_i,
    output logic         take_o
);
    brc_test_t tst;
    logic      bit_hit;
    logic      cnt_zero;
    logic      cnt_ok;
    logic      bit_ok;

    always_comb begin
        tst      = decode_mode(mode_i);
        bit_hit  = |(cr_i & mask_i);
        cnt_zero = (cnt_i == '0);
        cnt_ok   = tst.need_nz ? !cnt_zero : (tst.need_z ? cnt_zero : 1'b1);
        bit_ok   = tst.use_bit ? (bit_hit == tst.want_set) : 1'b1;
        take_o   = cnt_ok && bit_ok;
    end

endmodule

// File: rtl/brc_target_mux.sv
module brc_target_mux
    import brc_pkg::*;
#(
    parameter int W     = 32,
    parameter int ALIGN = 2
) (
    input  brc_tgt_e     sel_i,
    input  logic [W-1:0] imm_i,
    input  logic [W-1:0] ctr_i,
    input  logic [W-1:0] lr_i,
    output logic [W-1:0] tgt_o
);
    localparam logic [W-1:0] ALIGN_MASK = ~((W'(1) << ALIGN) - W'(1));

    always_comb begin
        case (sel_i)
            TGT_CTR: tgt_o = ctr_i & ALIGN_MASK;
            TGT_LR:  tgt_o = lr_i & ALIGN_MASK;
            default: tgt_o = imm_i;
        endcase
    end

endmodule

// File: rtl/brc_unit.sv
module brc_unit
    import brc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic [2:0]   mode_i,
    input  logic         dec_en_i,
    input  logic [1:0]   tgt_sel_i,
    input  logic [W-1:0] cr_i,
    input  logic [W-1:0] mask_i,
    input  logic [W-1:0] imm_tgt_i,
    input  logic [W-1:0] lr_i,
    input  logic [W-1:0] fall_addr_i,
    input  logic         ctr_load_i,
    input  logic [W-1:0] ctr_wdata_i,
    output logic         taken_o,
    output logic [W-1:0] next_addr_o,
    output logic         valid_o,
    output logic [W-1:0] ctr_o
);
    logic [W-1:0] ctr_q;
    logic [W-1:0] ctr_eval;
    logic         take;
    logic [W-1:0] tgt;
    brc_mode_e    mode;
    brc_tgt_e     tsel;

    assign mode = brc_mode_e'(mode_i);
    assign tsel = brc_tgt_e'(tgt_sel_i);

    brc_count_reg #(.W(W)) u_ctr (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .dec_en_i   (dec_en_i),
        .load_i     (ctr_load_i),
        .wdata_i    (ctr_wdata_i),
        .ctr_q_o    (ctr_q),
        .ctr_eval_o (ctr_eval)
    );

    brc_cond_eval #(.W(W)) u_eval (
        .mode_i (mode),
        .cr_i   (cr_i),
        .mask_i (mask_i),
        .cnt_i  (ctr_eval),
        .take_o (take)
    );

    brc_target_mux #(.W(W), .ALIGN(2)) u_tgt (
        .sel_i (tsel),
        .imm_i (imm_tgt_i),
        .ctr_i (ctr_q),
        .lr_i  (lr_i),
        .tgt_o (tgt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            taken_o     <= 1'b0;
            next_addr_o <= '0;
            valid_o     <= 1'b0;
        end else begin
            valid_o <= start_i;
            if (start_i) begin
                taken_o     <= take;
                next_addr_o <= take ? tgt : fall_addr_i;
            end
        end
    end

    assign ctr_o = ctr_q;

    AST_VALID_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        start_i |=> valid_o); // R7

    AST_VALID_ONLY_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> !valid_o); // R7

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> $stable(taken_o) && $stable(next_addr_o)); // R7

    AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (rst)
        start_i |=> taken_o || next_addr_o == $past(fall_addr_i)); // R6

    AST_REG_TGT_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        start_i && (tgt_sel_i == TGT_CTR || tgt_sel_i == TGT_LR)
        |=> !taken_o || next_addr_o[1:0] == 2'b00); // R5

    AST_NZ_LAST_ITER: assert property (@(posedge clk) disable iff (rst)
        start_i && dec_en_i && ctr_o == W'(1) && mode_i == MODE_NZ
        |=> !taken_o); // R2

endmodule

// File: tb/brc_unit_tb.sv
module brc_unit_tb;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_i = 1'b0;
    logic [2:0]   mode_i = '0;
    logic         dec_en_i = 1'b0;
    logic [1:0]   tgt_sel_i = '0;
    logic [W-1:0] cr_i = '0, mask_i = '0, imm_tgt_i = '0, lr_i = '0, fall_addr_i = '0;
    logic         ctr_load_i = 1'b0;
    logic [W-1:0] ctr_wdata_i = '0;
    logic         taken_o, valid_o;
    logic [W-1:0] next_addr_o, ctr_o;

    int checks = 0;
    int errors = 0;
    bit chk_en = 1'b0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    brc_unit #(.W(W)) u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i),
        .dec_en_i(dec_en_i), .tgt_sel_i(tgt_sel_i), .cr_i(cr_i), .mask_i(mask_i),
        .imm_tgt_i(imm_tgt_i), .lr_i(lr_i), .fall_addr_i(fall_addr_i),
        .ctr_load_i(ctr_load_i), .ctr_wdata_i(ctr_wdata_i),
        .taken_o(taken_o), .next_addr_o(next_addr_o), .valid_o(valid_o), .ctr_o(ctr_o)
    );

    // Behavioural reference model
    logic [W-1:0] m_ctr, m_next;
    logic         m_taken, m_valid;
    string        tag_c = "R9", tag_t = "R9", tag_n = "R9", tag_v = "R9";

    always @(posedge clk) begin
        logic [W-1:0] eff, tg;
        logic         hit, t;
        if (rst) begin
            m_ctr = '0; m_next = '0; m_taken = 1'b0; m_valid = 1'b0;
            tag_c = "R9"; tag_t = "R9"; tag_n = "R9"; tag_v = "R9";
        end else begin
            m_valid = start_i;
            tag_v = "R7";
            if (start_i) begin
                eff = dec_en_i ? m_ctr - 1 : m_ctr;
                hit = (cr_i & mask_i) != 0;
                case (mode_i)
                    3'd0: begin t = hit;                 tag_t = "R1"; end
                    3'd1: begin t = !hit;                tag_t = "R1"; end
                    3'd2: begin t = (eff != 0) && hit;   tag_t = "R2"; end
                    3'd3: begin t = (eff != 0) && !hit;  tag_t = "R2"; end
                    3'd4: begin t = (eff != 0);          tag_t = "R2"; end
                    3'd5: begin t = (eff == 0) && hit;   tag_t = "R3"; end
                    3'd6: begin t = (eff == 0) && !hit;  tag_t = "R3"; end
                    default: begin t = (eff == 0);       tag_t = "R3"; end
                endcase
                if (tgt_sel_i == 2'd1)      tg = {m_ctr[W-1:2], 2'b00};
                else if (tgt_sel_i == 2'd2) tg = {lr_i[W-1:2], 2'b00};
                else                        tg = imm_tgt_i;
                m_taken = t;
                m_next  = t ? tg : fall_addr_i;
                tag_n   = t ? "R5" : "R6";
                tag_c   = dec_en_i ? "R4" : "R8";
                m_ctr   = eff;
            end else begin
                tag_t = "R7"; tag_n = "R7";
                if (ctr_load_i) begin
                    m_ctr = ctr_wdata_i;
                    tag_c = "R8";
                end
            end
        end
    end

    task automatic cmp(input string tag, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (chk_en) begin
            cmp(tag_v, "valid", W'(valid_o), W'(m_valid));
            cmp(tag_t, "taken", W'(taken_o), W'(m_taken));
            cmp(tag_n, "next",  next_addr_o, m_next);
            cmp(tag_c, "count", ctr_o, m_ctr);
        end
    end

    task automatic issue(input logic [2:0] md, input logic dec, input logic [1:0] ts,
                         input logic [W-1:0] cr, input logic [W-1:0] mk,
                         input logic [W-1:0] imm, input logic [W-1:0] lr,
                         input logic [W-1:0] fa, input logic ld);
        @(negedge clk);
        start_i = 1'b1; mode_i = md; dec_en_i = dec; tgt_sel_i = ts;
        cr_i = cr; mask_i = mk; imm_tgt_i = imm; lr_i = lr; fall_addr_i = fa;
        ctr_load_i = ld; ctr_wdata_i = 32'hDEAD_BEEF;
        @(negedge clk);
        start_i = 1'b0; ctr_load_i = 1'b0;
    endtask

    task automatic load(input logic [W-1:0] v);
        @(negedge clk);
        ctr_load_i = 1'b1; ctr_wdata_i = v;
        @(negedge clk);
        ctr_load_i = 1'b0;
    endtask

    initial begin
        @(posedge clk);
        chk_en = 1'b1;                   // R9: reset values checked
        repeat (3) @(negedge clk);
        rst = 1'b0;
        load(32'd3);                                                         // R8
        issue(3'd2, 1, 2'd0, 32'h10, 32'h10, 32'h1000, 0, 32'h44, 0);        // R2 taken, ctr 2
        issue(3'd3, 1, 2'd0, 32'h10, 32'h10, 32'h1000, 0, 32'h48, 0);        // R2 not taken, ctr 1
        issue(3'd4, 1, 2'd0, 0, 32'h1, 32'h1000, 0, 32'h4C, 0);              // R2 eff 0 -> not taken
        issue(3'd7, 1, 2'd0, 0, 32'h1, 32'h1000, 0, 32'h50, 0);              // R4 wrap to all ones
        load(32'd1);
        issue(3'd7, 1, 2'd1, 0, 32'h1, 32'h1000, 0, 32'h54, 0);              // R3 taken, R5 ctr target
        issue(3'd0, 0, 2'd2, 32'h8000_0000, 32'h8000_0000, 0, 32'h2003, 32'h58, 0); // R1 R5 link
        issue(3'd1, 0, 2'd2, 32'h8000_0000, 32'h8000_0000, 0, 32'h2003, 32'h5C, 0); // R1 R6
        issue(3'd5, 0, 2'd0, 32'h4, 32'h4, 32'h3000, 0, 32'h60, 0);          // R3 zero + set
        issue(3'd6, 0, 2'd0, 32'h4, 32'h4, 32'h3000, 0, 32'h64, 0);          // R3 zero + clear -> no
        issue(3'd0, 0, 2'd3, 32'h2, 32'h2, 32'h1233, 0, 32'h68, 0);          // R5 reserved sel -> imm
        load(32'd9);
        issue(3'd4, 0, 2'd1, 0, 32'h1, 0, 0, 32'h6C, 1);                     // R8 load ignored, R5 ctr 9->8
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            start_i     = ($urandom % 3) == 0;
            mode_i      = 3'($urandom);
            dec_en_i    = 1'($urandom);
            tgt_sel_i   = 2'($urandom);
            cr_i        = $urandom;
            mask_i      = 32'h1 << ($urandom % 32);
            imm_tgt_i   = $urandom;
            lr_i        = $urandom;
            fall_addr_i = $urandom;
            ctr_load_i  = ($urandom % 4) == 0;
            ctr_wdata_i = ($urandom % 2) ? 32'($urandom % 3) : $urandom;
        end
        @(negedge clk);
        start_i = 1'b0; ctr_load_i = 1'b0;
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R7 watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule